// File: doc/BRIEF.md
# Privileged Interrupt Selection Arbiter

This block decides, once per clock, whether a hart should take an interrupt and which interrupt to take. It takes the raw pending lines, the per-line enable mask, the per-line delegation mask, the hart's current privilege level and two global enable bits, one for the machine level and one for the supervisor level. From these it forms two candidate sets. Lines that are not delegated are gated by the machine-level rule. Lines that are delegated are gated by the supervisor-level rule. The union of the two sets goes to a fixed-priority pick in which the lowest line number wins.

The result is registered. A one-cycle take strobe rises when at least one line is eligible and the core reports that it stands at an instruction boundary. A cause word carries the winning line number in its low bits and a set most significant bit, which marks the cause as an interrupt and not an exception. The trap-entry sequencer reads both outputs and performs the actual redirect. Storage of the masks and status bits lives elsewhere.

Top module: `irq_pick_top`

## Requirements
- R1: While reset (rstN low) is asserted, and at the first sample after it, takeIrq is 0 and causeWord is all zeros.
- R2: A line is a candidate only if both its pending bit and its enable bit are 1. A pending line whose enable bit is 0 is never reported.
- R3: A non-delegated line (delegMask bit 0) is eligible at privilege U (2'd0) or S (2'd1) whatever mGlobalEn holds. At privilege M (2'd3) it is eligible only when mGlobalEn is 1.
- R4: A delegated line (delegMask bit 1) is eligible at privilege U whatever sGlobalEn holds, at privilege S only when sGlobalEn is 1, and never at privilege M.
- R5: The eligible set is the union of the eligible non-delegated lines and the eligible delegated lines. A line blocked in one class does not hide an eligible line of the other class.
- R6: When several lines are eligible, the lowest-numbered line wins.
- R7: One clock edge after the inputs are sampled, causeWord holds the winning line number in bits [IDXW-1:0], bit XLEN-1 set, and every other bit zero. This happens whether or not instBoundary is high.
- R8: takeIrq is high for the cycle after an edge at which instBoundary was 1 and the eligible set was non-empty. It is low after any edge at which either condition failed.
- R9: When the eligible set is empty, takeIrq is 0 and causeWord is all zeros after the next edge.
- R10: The unused privilege code 2'd2 counts as below M and above S. Non-delegated lines are eligible at that code, and delegated lines are not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pendVec | input | NUM_IRQ | Pending interrupt lines |
| enableVec | input | NUM_IRQ | Per-line enable mask |
| delegMask | input | NUM_IRQ | Per-line delegation to supervisor level |
| privLvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mGlobalEn | input | 1 | Machine-level global interrupt enable |
| sGlobalEn | input | 1 | Supervisor-level global interrupt enable |
| instBoundary | input | 1 | Core is at a point where an interrupt may be taken |
| takeIrq | output | 1 | Registered strobe: take the interrupt now |
| causeWord | output | XLEN | Registered cause: interrupt flag in MSB, line number in low bits |

## Verification
Each stimulus vector sets one line, or a few, in a chosen pending, enable and delegation pattern at one privilege level, then compares the strobe and the cause word. Patterns with several lines at machine level, or one masked-off lower line, separate a lowest-index pick from a highest-index pick and from a pick that ignores the enable mask. Single delegated or non-delegated lines swept across U, S, M and the spare code, with each global enable toggled, separate the two gating rules from each other and catch any swap of the comparisons. Mixed patterns, in which one class is blocked and the other is open, show that both sets are ORed. Boundary-low and empty vectors, and a mid-run reset, show that the strobe and the cause are kept apart from one another.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

  // Privilege encodings; the order matters for "below" comparisons.
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_SPARE = 2'd2,
    PRIV_MACH  = 2'd3
  } privLevelE;

  // Strobes from control into the datapath.
  typedef struct packed {
    logic mAllow;     // non-delegated class may be taken
    logic sAllow;     // delegated class may be taken
    logic atBoundary; // core can accept a redirect
  } ctrlStrobeS;

endpackage

// File: rtl/irq_pick_ctrl.sv
module irq_pick_ctrl
  import irq_pick_pkg::*;
(
  input  logic [1:0] privLvl,
  input  logic       mGlobalEn,
  input  logic       sGlobalEn,
  input  logic       instBoundary,
  output ctrlStrobeS ctrlOut
);

  privLevelE curPriv;

  always_comb begin
    curPriv = privLevelE'(privLvl);

    // Machine-handled lines: open below machine level, or at machine
    // level when its global enable is set.
    ctrlOut.mAllow = (curPriv != PRIV_MACH) || mGlobalEn;

    // Delegated lines: open below supervisor level, or at supervisor
    // level when its global enable is set. Spare and machine codes close.
    ctrlOut.sAllow = (curPriv == PRIV_USER) ||
                     ((curPriv == PRIV_SUPER) && sGlobalEn);

    ctrlOut.atBoundary = instBoundary;
  end

endmodule

// File: rtl/irq_pick_gate.sv
module irq_pick_gate #(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] pendVec,
  input  logic [NUM_IRQ-1:0] enableVec,
  input  logic [NUM_IRQ-1:0] delegMask,
  input  logic               mAllow,
  input  logic               sAllow,
  output logic [NUM_IRQ-1:0] eligVec
);

  logic [NUM_IRQ-1:0] candVec;
  logic [NUM_IRQ-1:0] machSet;
  logic [NUM_IRQ-1:0] superSet;

  always_comb begin
    candVec  = pendVec & enableVec;
    machSet  = candVec & ~delegMask & {NUM_IRQ{mAllow}};
    superSet = candVec &  delegMask & {NUM_IRQ{sAllow}};
    eligVec  = machSet | superSet;
  end

endmodule

// File: rtl/irq_pick_prio.sv
module irq_pick_prio #(
  parameter int NUM_IRQ = 16,
  localparam int IDXW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] reqVec,
  output logic               anyReq,
  output logic [IDXW-1:0]    winIdx
);

  // Trailing-zero count: scan from the top so the lowest set bit is the
  // last one written.
  always_comb begin
    winIdx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (reqVec[i]) winIdx = IDXW'(i);
    end
    anyReq = |reqVec;
  end

endmodule

// File: rtl/irq_pick_dpath.sv
module irq_pick_dpath
  import irq_pick_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 16,
  localparam int IDXW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] pendVec,
  input  logic [NUM_IRQ-1:0] enableVec,
  input  logic [NUM_IRQ-1:0] delegMask,
  input  ctrlStrobeS         ctrlIn,
  output logic               takeIrq,
  output logic [XLEN-1:0]    causeWord
);

  logic [NUM_IRQ-1:0] eligVec;
  logic               anyElig;
  logic [IDXW-1:0]    winIdx;
  logic [XLEN-1:0]    causeNext;

  irq_pick_gate #(.NUM_IRQ(NUM_IRQ)) gate_i (
    .pendVec  (pendVec),
    .enableVec(enableVec),
    .delegMask(delegMask),
    .mAllow   (ctrlIn.mAllow),
    .sAllow   (ctrlIn.sAllow),
    .eligVec  (eligVec)
  );

  irq_pick_prio #(.NUM_IRQ(NUM_IRQ)) prio_i (
    .reqVec(eligVec),
    .anyReq(anyElig),
    .winIdx(winIdx)
  );

  always_comb begin
    causeNext = '0;
    if (anyElig) begin
      causeNext[IDXW-1:0] = winIdx;
      causeNext[XLEN-1]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeIrq   <= 1'b0;
      causeWord <= '0;
    end else begin
      takeIrq   <= anyElig && ctrlIn.atBoundary;
      causeWord <= causeNext;
    end
  end

endmodule

// File: rtl/irq_pick_top.sv
module irq_pick_top
  import irq_pick_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] pendVec,
  input  logic [NUM_IRQ-1:0] enableVec,
  input  logic [NUM_IRQ-1:0] delegMask,
  input  logic [1:0]         privLvl,
  input  logic               mGlobalEn,
  input  logic               sGlobalEn,
  input  logic               instBoundary,
  output logic               takeIrq,
  output logic [XLEN-1:0]    causeWord
);

  ctrlStrobeS ctrlBus;

  irq_pick_ctrl ctrl_i (
    .privLvl     (privLvl),
    .mGlobalEn   (mGlobalEn),
    .sGlobalEn   (sGlobalEn),
    .instBoundary(instBoundary),
    .ctrlOut     (ctrlBus)
  );

  irq_pick_dpath #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .pendVec  (pendVec),
    .enableVec(enableVec),
    .delegMask(delegMask),
    .ctrlIn   (ctrlBus),
    .takeIrq  (takeIrq),
    .causeWord(causeWord)
  );

endmodule

// File: rtl/irq_pick_chk.sv
module irq_pick_chk #(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 16,
  localparam int IDXW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_IRQ-1:0] pendVec,
  input logic [NUM_IRQ-1:0] enableVec,
  input logic [1:0]         privLvl,
  input logic               mGlobalEn,
  input logic               instBoundary,
  input logic               takeIrq,
  input logic [XLEN-1:0]    causeWord
);

  // R8: a strobe always comes with a valid interrupt cause.
  p_take_has_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> causeWord[XLEN-1]);

  // R8: a strobe needs the boundary indication at the sampling edge.
  p_take_needs_boundary_r8: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(instBoundary));

  // R2: the reported line was pending and enabled when sampled.
  p_cause_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    causeWord[XLEN-1] |->
      ((($past(pendVec & enableVec) >> causeWord[IDXW-1:0]) & NUM_IRQ'(1)) != '0));

  // R9: no candidate lines, nothing reported next cycle.
  p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & enableVec) == '0) |=> (!takeIrq && causeWord == '0));

  // R3 / R4: machine level with its global enable clear admits no line.
  p_mach_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (privLvl == 2'd3 && !mGlobalEn) |=> (causeWord == '0));

  // R7: only the flag bit and the index field may be set.
  p_cause_shape_r7: assert property (@(posedge clk) disable iff (!rstN)
    (causeWord[XLEN-2:IDXW] == '0));

endmodule

bind irq_pick_top irq_pick_chk #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .pendVec     (pendVec),
  .enableVec   (enableVec),
  .privLvl     (privLvl),
  .mGlobalEn   (mGlobalEn),
  .instBoundary(instBoundary),
  .takeIrq     (takeIrq),
  .causeWord   (causeWord)
);

// File: tb/irq_pick_top_tb_top.sv
`timescale 1ns/1ps
module irq_pick_top_tb_top;

  localparam int XLEN    = 32;
  localparam int NUM_IRQ = 16;
  localparam int NV      = 13;
  localparam int VW      = 59;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_IRQ-1:0] pendVec = '0;
  logic [NUM_IRQ-1:0] enableVec = '0;
  logic [NUM_IRQ-1:0] delegMask = '0;
  logic [1:0]         privLvl = 2'd3;
  logic               mGlobalEn = 1'b0;
  logic               sGlobalEn = 1'b0;
  logic               instBoundary = 1'b0;
  logic               takeIrq;
  logic [XLEN-1:0]    causeWord;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  finished   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  irq_pick_top #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) dut_i (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enableVec(enableVec),
    .delegMask(delegMask), .privLvl(privLvl), .mGlobalEn(mGlobalEn),
    .sGlobalEn(sGlobalEn), .instBoundary(instBoundary),
    .takeIrq(takeIrq), .causeWord(causeWord)
  );

  // {pend, enable, deleg, priv, mGlobalEn, sGlobalEn, boundary,
  //  expTake, expAny, expIdx}
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'h0028, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3},  // R6
    {16'h0028, 16'h0020, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5},  // R2
    {16'h00FF, 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0},  // R3
    {16'h00FF, 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0},  // R3
    {16'h0002, 16'hFFFF, 16'h0002, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0},  // R4
    {16'h0002, 16'hFFFF, 16'h0002, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0},  // R4
    {16'h0002, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd1},  // R4
    {16'h0002, 16'hFFFF, 16'h0002, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1},  // R4
    {16'h0006, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2},  // R5
    {16'h0006, 16'hFFFF, 16'h0004, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd1},  // R5
    {16'h8000, 16'h8000, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd15}, // R8 R7
    {16'h0003, 16'hFFFF, 16'h0001, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd1},  // R10
    {16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0}   // R9
  };

  string vecTag [NV] = '{"R6", "R2", "R3", "R3", "R4", "R4", "R4", "R4",
                         "R5", "R5", "R8/R7", "R10", "R9"};

  task automatic checkOut(input string tag, input logic expTake,
                          input logic [XLEN-1:0] expCause);
    checkCount++;
    if (takeIrq !== expTake) begin
      failCount++;
      $display("FAIL %s takeIrq actual=%0b expected=%0b", tag, takeIrq, expTake);
    end
    checkCount++;
    if (causeWord !== expCause) begin
      failCount++;
      $display("FAIL %s causeWord actual=%h expected=%h", tag, causeWord, expCause);
    end
  endtask

  function automatic logic [XLEN-1:0] mkCause(input logic any, input logic [3:0] idx);
    logic [XLEN-1:0] c;
    c = '0;
    if (any) begin
      c[3:0]      = idx;
      c[XLEN-1]   = 1'b1;
    end
    return c;
  endfunction

  initial begin
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    checkOut("R1", 1'b0, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1", 1'b0, '0);

    // Vector table: drive at negedge, result registered at next posedge.
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      pendVec      = v[58:43];
      enableVec    = v[42:27];
      delegMask    = v[26:11];
      privLvl      = v[10:9];
      mGlobalEn    = v[8];
      sGlobalEn    = v[7];
      instBoundary = v[6];
      @(negedge clk);
      checkOut(vecTag[i], v[5], mkCause(v[4], v[3:0]));
    end

    // R8: strobe repeats while conditions hold, drops with boundary low.
    pendVec = 16'h0010; enableVec = 16'hFFFF; delegMask = '0;
    privLvl = 2'd0; mGlobalEn = 1'b0; sGlobalEn = 1'b0; instBoundary = 1'b1;
    @(negedge clk);
    checkOut("R8", 1'b1, mkCause(1'b1, 4'd4));
    instBoundary = 1'b0;
    @(negedge clk);
    checkOut("R8", 1'b0, mkCause(1'b1, 4'd4));

    // R1: reset in the middle of an active strobe clears both outputs.
    instBoundary = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkOut("R1", 1'b0, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R7", 1'b1, mkCause(1'b1, 4'd4));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule